// File: doc/BRIEF.md
# Fully Associative Translation Cache with Stamp-Based Replacement

The block caches virtual-to-physical page translations in a parameterised number of fully associative slots. Each slot holds an aligned virtual page, an aligned physical page, a page-size code and four attribute bits: global, writable, user and uncacheable. A single command port accepts lookups, inserts, a full flush, a flush that spares global pages, and a single-page demap. Every accepted command produces one registered response on the next cycle.

Lookups compare the address against all slots in parallel. Each slot uses a mask that comes from its own page size. On a hit the block builds the physical address and runs the paging permission checks for the access described alongside the command. Replacement keeps one running sequence counter. Each slot records the counter value from the last time it was filled or, if the caller asks, from the last time a lookup refreshed it. When no slot is free, the slot with the oldest record is the one replaced.

Top module: `tlb_fa`

## Requirements
- R1: After reset every slot is free, `rsp_valid_o` is low and `cmd_ready_o` is high, so a lookup of any address misses.
- R2: A lookup (op code 0) that hits returns `rsp_hit_o`=1 and a physical address equal to the slot's physical page ORed with the low offset bits of the address. The offset is 12 bits for size code 0, 21 bits for code 1 and 30 bits for code 2.
- R3: A lookup that matches no valid slot returns hit, fault and uncacheable all 0 and an address of 0.
- R4: An insert (op code 1) whose address already matches a valid slot allocates nothing and leaves that slot unchanged. It returns `rsp_hit_o`=1 and that slot's index.
- R5: An insert with no matching slot fills the lowest-index free slot when one exists, and returns `rsp_hit_o`=0 and the index it filled.
- R6: An insert with no free slot replaces the valid slot with the smallest sequence record, the lower index winning a tie. A fill, and a hit lookup with `lru_touch_i`=1, each record the next counter value. A lookup with `lru_touch_i`=0 leaves the records alone.
- R7: Flush-all (op code 2) frees every slot.
- R8: Flush-non-global (op code 3) frees exactly the valid slots whose global bit is clear and keeps the global ones.
- R9: Demap (op code 4) frees the one slot that the given address hits and reports `rsp_hit_o`=1. If no slot matches, it frees nothing.
- R10: An access counts as a user access when `cpl_i`=3 and `force_sup_i`=0. A write is bad when the slot is not writable and the access is either a user access or `wp_i`=1. A hit faults when a user access meets a slot with user=0, or when a write is a bad write.
- R11: A read with `acc_store_chk_i`=1 that would be a bad write also faults, and that fault is reported with `rsp_fault_write_o`=1. For the other faults `rsp_fault_write_o` equals `acc_write_i`.
- R12: A hit without a fault on an uncacheable slot raises both `rsp_uncache_o` and `rsp_strict_o`. Otherwise both are 0.
- R13: `rsp_valid_o` is high in exactly the cycle after a command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Command can be accepted |
| cmd_op_i | input | 3 | Operation code |
| cmd_va_i | input | VA_W | Virtual address to look up, insert or demap |
| ins_pa_i | input | PA_W | Physical page to insert |
| ins_size_i | input | 2 | Page-size code to insert |
| ins_global_i | input | 1 | Global attribute to insert |
| ins_writable_i | input | 1 | Writable attribute to insert |
| ins_user_i | input | 1 | User attribute to insert |
| ins_uncache_i | input | 1 | Uncacheable attribute to insert |
| lru_touch_i | input | 1 | Lookup refreshes the sequence record of the slot it hits |
| acc_write_i | input | 1 | Access is a write |
| acc_store_chk_i | input | 1 | Read that must also pass a write check |
| cpl_i | input | 2 | Current privilege level |
| force_sup_i | input | 1 | Treat the access as supervisor |
| wp_i | input | 1 | Supervisor write protection enable |
| rsp_valid_o | output | 1 | Response present |
| rsp_hit_o | output | 1 | Matching slot found |
| rsp_index_o | output | IDX_W | Slot index that hit or was filled |
| rsp_pa_o | output | PA_W | Translated physical address |
| rsp_fault_o | output | 1 | Page fault |
| rsp_fault_write_o | output | 1 | Fault is reported as a write |
| rsp_uncache_o | output | 1 | Request is uncacheable |
| rsp_strict_o | output | 1 | Request is strictly ordered |

## Verification
The bench builds the block with NUM_ENTRIES=4 and 48-bit addresses. Four inserts then fill the cache, so the same table of entries exercises all three page sizes and every combination of the permission flags. The small size also makes it cheap to reach the full condition. Because of that, a refreshed slot, an unrefreshed slot and a slot that a demap just freed can each be steered into being the next one filled, and the index the block picks can be compared against the expected one.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [2:0] {
    OP_LOOKUP    = 3'd0,
    OP_INSERT    = 3'd1,
    OP_FLUSH_ALL = 3'd2,
    OP_FLUSH_NG  = 3'd3,
    OP_DEMAP     = 3'd4
  } tlb_op_e;

  typedef enum logic [1:0] {
    PG_4K = 2'd0,
    PG_2M = 2'd1,
    PG_1G = 2'd2
  } pg_size_e;

  function automatic int unsigned pg_log2(input logic [1:0] code);
    case (code)
      PG_2M:   return 21;
      PG_1G:   return 30;
      default: return 12;
    endcase
  endfunction
endpackage

// File: rtl/tlb_entry.sv
module tlb_entry #(
  parameter int VA_W  = 48,
  parameter int PA_W  = 48,
  parameter int SEQ_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             inv_i,
  input  logic             touch_i,
  input  logic [SEQ_W-1:0] stamp_i,
  input  logic [VA_W-1:0]  ins_va_i,
  input  logic [PA_W-1:0]  ins_pa_i,
  input  logic [1:0]       ins_size_i,
  input  logic             ins_glob_i,
  input  logic             ins_wr_i,
  input  logic             ins_user_i,
  input  logic             ins_unc_i,
  input  logic [VA_W-1:0]  cmp_va_i,
  output logic             valid_o,
  output logic             match_o,
  output logic             glob_o,
  output logic             writable_o,
  output logic             user_o,
  output logic             unc_o,
  output logic [PA_W-1:0]  pa_o,
  output logic [VA_W-1:0]  offs_mask_o,
  output logic [SEQ_W-1:0] stamp_o
);
  import tlb_pkg::*;

  logic             valid_q, glob_q, wr_q, user_q, unc_q;
  logic [1:0]       size_q;
  logic [VA_W-1:0]  va_q;
  logic [PA_W-1:0]  pa_q;
  logic [SEQ_W-1:0] stamp_q;
  logic [VA_W-1:0]  new_mask_va;
  logic [PA_W-1:0]  new_mask_pa;

  always_comb begin
    new_mask_va = (VA_W'(1) << pg_log2(ins_size_i)) - VA_W'(1);
    new_mask_pa = (PA_W'(1) << pg_log2(ins_size_i)) - PA_W'(1);
    offs_mask_o = (VA_W'(1) << pg_log2(size_q)) - VA_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      glob_q  <= 1'b0;
      wr_q    <= 1'b0;
      user_q  <= 1'b0;
      unc_q   <= 1'b0;
      size_q  <= 2'd0;
      va_q    <= '0;
      pa_q    <= '0;
      stamp_q <= '0;
    end else if (wr_i) begin
      valid_q <= 1'b1;
      glob_q  <= ins_glob_i;
      wr_q    <= ins_wr_i;
      user_q  <= ins_user_i;
      unc_q   <= ins_unc_i;
      size_q  <= ins_size_i;
      va_q    <= ins_va_i & ~new_mask_va;
      pa_q    <= ins_pa_i & ~new_mask_pa;
      stamp_q <= stamp_i;
    end else begin
      if (inv_i)   valid_q <= 1'b0;
      if (touch_i) stamp_q <= stamp_i;
    end
  end

  assign match_o    = valid_q && (((cmp_va_i ^ va_q) & ~offs_mask_o) == '0);
  assign valid_o    = valid_q;
  assign glob_o     = glob_q;
  assign writable_o = wr_q;
  assign user_o     = user_q;
  assign unc_o      = unc_q;
  assign pa_o       = pa_q;
  assign stamp_o    = stamp_q;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N     = 8,
  parameter int SEQ_W = 32,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     valid_i,
  input  logic [SEQ_W-1:0] stamp_i [N],
  output logic             has_free_o,
  output logic [IDX_W-1:0] free_idx_o,
  output logic [IDX_W-1:0] oldest_idx_o
);
  logic [SEQ_W-1:0] best;

  always_comb begin
    has_free_o = 1'b0;
    free_idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        has_free_o = 1'b1;
        free_idx_o = IDX_W'(i);
      end
    end
  end

  // strict less-than keeps the lower index on equal stamps
  always_comb begin
    oldest_idx_o = '0;
    best         = stamp_i[0];
    for (int i = 1; i < N; i++) begin
      if (stamp_i[i] < best) begin
        best         = stamp_i[i];
        oldest_idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm (
  input  logic [1:0] cpl_i,
  input  logic       force_sup_i,
  input  logic       wp_i,
  input  logic       is_write_i,
  input  logic       store_chk_i,
  input  logic       writable_i,
  input  logic       user_page_i,
  output logic       fault_o,
  output logic       fault_write_o
);
  logic in_user, bad_write, primary;

  always_comb begin
    in_user       = (cpl_i == 2'd3) && !force_sup_i;
    bad_write     = !writable_i && (in_user || wp_i);
    primary       = (in_user && !user_page_i) || (is_write_i && bad_write);
    fault_o       = primary || (store_chk_i && bad_write);
    fault_write_o = primary ? is_write_i : fault_o;
  end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa #(
  parameter int NUM_ENTRIES = 8,
  parameter int VA_W        = 48,
  parameter int PA_W        = 48,
  parameter int SEQ_W       = 32,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic [2:0]       cmd_op_i,
  input  logic [VA_W-1:0]  cmd_va_i,
  input  logic [PA_W-1:0]  ins_pa_i,
  input  logic [1:0]       ins_size_i,
  input  logic             ins_global_i,
  input  logic             ins_writable_i,
  input  logic             ins_user_i,
  input  logic             ins_uncache_i,
  input  logic             lru_touch_i,
  input  logic             acc_write_i,
  input  logic             acc_store_chk_i,
  input  logic [1:0]       cpl_i,
  input  logic             force_sup_i,
  input  logic             wp_i,
  output logic             rsp_valid_o,
  output logic             rsp_hit_o,
  output logic [IDX_W-1:0] rsp_index_o,
  output logic [PA_W-1:0]  rsp_pa_o,
  output logic             rsp_fault_o,
  output logic             rsp_fault_write_o,
  output logic             rsp_uncache_o,
  output logic             rsp_strict_o
);
  import tlb_pkg::*;

  logic [NUM_ENTRIES-1:0] valid_vec, match_vec, glob_vec, wrb_vec, user_vec, unc_vec;
  logic [NUM_ENTRIES-1:0] wr_vec, inv_vec, touch_vec;
  logic [PA_W-1:0]        pa_arr    [NUM_ENTRIES];
  logic [VA_W-1:0]        mask_arr  [NUM_ENTRIES];
  logic [SEQ_W-1:0]       stamp_arr [NUM_ENTRIES];
  logic [SEQ_W-1:0]       seq_q, seq_nxt;

  logic             accept, hit_any, ins_new;
  logic [IDX_W-1:0] hit_idx, free_idx, oldest_idx, alloc_idx;
  logic             has_free;
  tlb_op_e          op;

  assign cmd_ready_o = 1'b1;
  assign accept      = cmd_valid_i && cmd_ready_o;
  assign op          = tlb_op_e'(cmd_op_i);
  assign seq_nxt     = seq_q + SEQ_W'(1);

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    tlb_entry #(.VA_W(VA_W), .PA_W(PA_W), .SEQ_W(SEQ_W)) u_ent (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (wr_vec[g]),
      .inv_i       (inv_vec[g]),
      .touch_i     (touch_vec[g]),
      .stamp_i     (seq_nxt),
      .ins_va_i    (cmd_va_i),
      .ins_pa_i    (ins_pa_i),
      .ins_size_i  (ins_size_i),
      .ins_glob_i  (ins_global_i),
      .ins_wr_i    (ins_writable_i),
      .ins_user_i  (ins_user_i),
      .ins_unc_i   (ins_uncache_i),
      .cmp_va_i    (cmd_va_i),
      .valid_o     (valid_vec[g]),
      .match_o     (match_vec[g]),
      .glob_o      (glob_vec[g]),
      .writable_o  (wrb_vec[g]),
      .user_o      (user_vec[g]),
      .unc_o       (unc_vec[g]),
      .pa_o        (pa_arr[g]),
      .offs_mask_o (mask_arr[g]),
      .stamp_o     (stamp_arr[g])
    );
  end

  // lowest matching index wins when page sizes overlap
  always_comb begin
    hit_idx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) hit_idx = IDX_W'(i);
    end
  end
  assign hit_any = |match_vec;

  tlb_victim #(.N(NUM_ENTRIES), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_victim (
    .valid_i      (valid_vec),
    .stamp_i      (stamp_arr),
    .has_free_o   (has_free),
    .free_idx_o   (free_idx),
    .oldest_idx_o (oldest_idx)
  );

  assign alloc_idx = has_free ? free_idx : oldest_idx;
  assign ins_new   = accept && (op == OP_INSERT) && !hit_any;

  always_comb begin
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      wr_vec[i]    = ins_new && (alloc_idx == IDX_W'(i));
      touch_vec[i] = accept && (op == OP_LOOKUP) && lru_touch_i && hit_any
                     && (hit_idx == IDX_W'(i));
      inv_vec[i]   = 1'b0;
      if (accept) begin
        case (op)
          OP_FLUSH_ALL: inv_vec[i] = 1'b1;
          OP_FLUSH_NG:  inv_vec[i] = !glob_vec[i];
          OP_DEMAP:     inv_vec[i] = hit_any && (hit_idx == IDX_W'(i));
          default:      inv_vec[i] = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       seq_q <= '0;
    else if (ins_new || (|touch_vec))  seq_q <= seq_nxt;
  end

  logic            sel_wr, sel_user, sel_unc, perm_fault, perm_fw;
  logic [PA_W-1:0] sel_pa;
  logic [VA_W-1:0] sel_mask;

  always_comb begin
    sel_wr   = wrb_vec[hit_idx];
    sel_user = user_vec[hit_idx];
    sel_unc  = unc_vec[hit_idx];
    sel_pa   = pa_arr[hit_idx];
    sel_mask = mask_arr[hit_idx];
  end

  tlb_perm u_perm (
    .cpl_i         (cpl_i),
    .force_sup_i   (force_sup_i),
    .wp_i          (wp_i),
    .is_write_i    (acc_write_i),
    .store_chk_i   (acc_store_chk_i),
    .writable_i    (sel_wr),
    .user_page_i   (sel_user),
    .fault_o       (perm_fault),
    .fault_write_o (perm_fw)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o       <= 1'b0;
      rsp_hit_o         <= 1'b0;
      rsp_index_o       <= '0;
      rsp_pa_o          <= '0;
      rsp_fault_o       <= 1'b0;
      rsp_fault_write_o <= 1'b0;
      rsp_uncache_o     <= 1'b0;
      rsp_strict_o      <= 1'b0;
    end else begin
      rsp_valid_o <= accept;
      if (accept) begin
        rsp_hit_o         <= 1'b0;
        rsp_index_o       <= hit_idx;
        rsp_pa_o          <= '0;
        rsp_fault_o       <= 1'b0;
        rsp_fault_write_o <= 1'b0;
        rsp_uncache_o     <= 1'b0;
        rsp_strict_o      <= 1'b0;
        case (op)
          OP_LOOKUP: if (hit_any) begin
            rsp_hit_o         <= 1'b1;
            rsp_pa_o          <= sel_pa | PA_W'(cmd_va_i & sel_mask);
            rsp_fault_o       <= perm_fault;
            rsp_fault_write_o <= perm_fw;
            rsp_uncache_o     <= sel_unc && !perm_fault;
            rsp_strict_o      <= sel_unc && !perm_fault;
          end
          OP_INSERT: begin
            rsp_hit_o   <= hit_any;
            rsp_index_o <= hit_any ? hit_idx : alloc_idx;
          end
          OP_DEMAP: rsp_hit_o <= hit_any;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
  parameter int N     = 8,
  parameter int SEQ_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic [2:0]       cmd_op_i,
  input logic             rsp_valid_o,
  input logic             rsp_hit_o,
  input logic             rsp_fault_o,
  input logic             rsp_uncache_o,
  input logic             rsp_strict_o,
  input logic [N-1:0]     valid_vec,
  input logic [N-1:0]     glob_vec,
  input logic [SEQ_W-1:0] seq_q
);
  p_rsp_follows_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> rsp_valid_o);
  p_rsp_idle_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !rsp_valid_o);
  p_flush_all_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 3'd2) |=> (valid_vec == '0));
  p_flush_ng_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 3'd3) |=> (valid_vec == ($past(valid_vec) & $past(glob_vec))));
  p_fault_needs_hit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o) |-> rsp_hit_o);
  p_uncache_clean_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_uncache_o |-> (rsp_hit_o && !rsp_fault_o && rsp_strict_o));
  p_seq_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_q == $past(seq_q)) || (seq_q == $past(seq_q) + SEQ_W'(1)));
endmodule

bind tlb_fa tlb_fa_chk #(.N(NUM_ENTRIES), .SEQ_W(SEQ_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cmd_valid_i   (cmd_valid_i),
  .cmd_op_i      (cmd_op_i),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_hit_o     (rsp_hit_o),
  .rsp_fault_o   (rsp_fault_o),
  .rsp_uncache_o (rsp_uncache_o),
  .rsp_strict_o  (rsp_strict_o),
  .valid_vec     (valid_vec),
  .glob_vec      (glob_vec),
  .seq_q         (seq_q)
);

// File: tb/tb_tlb_fa.sv
module tb_tlb_fa;
  localparam int N  = 4;
  localparam int VW = 48;
  localparam int PW = 48;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [2:0]    cmd_op = '0;
  logic [VW-1:0] cmd_va = '0;
  logic [PW-1:0] ins_pa = '0;
  logic [1:0]    ins_size = '0;
  logic          ins_g = 0, ins_w = 0, ins_u = 0, ins_unc = 0;
  logic          touch = 0, acc_wr = 0, acc_sc = 0, fsup = 0, wp = 0;
  logic [1:0]    cpl = '0;
  logic          rsp_valid, rsp_hit, rsp_fault, rsp_fw, rsp_unc, rsp_strict;
  logic [IW-1:0] rsp_idx;
  logic [PW-1:0] rsp_pa;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  tlb_fa #(.NUM_ENTRIES(N), .VA_W(VW), .PA_W(PW), .SEQ_W(32)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_op_i(cmd_op), .cmd_va_i(cmd_va), .ins_pa_i(ins_pa), .ins_size_i(ins_size),
    .ins_global_i(ins_g), .ins_writable_i(ins_w), .ins_user_i(ins_u),
    .ins_uncache_i(ins_unc), .lru_touch_i(touch), .acc_write_i(acc_wr),
    .acc_store_chk_i(acc_sc), .cpl_i(cpl), .force_sup_i(fsup), .wp_i(wp),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_index_o(rsp_idx),
    .rsp_pa_o(rsp_pa), .rsp_fault_o(rsp_fault), .rsp_fault_write_o(rsp_fw),
    .rsp_uncache_o(rsp_unc), .rsp_strict_o(rsp_strict)
  );

  // va, cpl, fsup, wp, wr, sc, hit, fault, fw, unc, pa
  typedef struct packed {
    logic [47:0] va;
    logic [1:0]  cpl;
    logic        fs, wp, wr, sc;
    logic        hit, flt, fw, unc;
    logic [47:0] pa;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{48'h1234,     2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 48'h555234},
    '{48'h1abc,     2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 48'h555abc},
    '{48'h2010,     2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 48'h777010},
    '{48'h2010,     2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 48'h777010},
    '{48'h2010,     2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 48'h777010},
    '{48'h2010,     2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 48'h777010},
    '{48'h2ff8,     2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 48'h777ff8},
    '{48'h456789,   2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 48'h12256789},
    '{48'h456789,   2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 48'h12256789},
    '{48'h456789,   2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 48'h12256789},
    '{48'h7ffffff0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 48'hbffffff0},
    '{48'h7ffffff0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 48'hbffffff0},
    '{48'h40000000, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 48'h80000000},
    '{48'h900000,   2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 48'h0},
    '{48'h7ffffff0, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 48'hbffffff0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [47:0] va);
    @(negedge clk);
    cmd_op    = op;
    cmd_va    = va;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R13 rsp_valid", 64'(rsp_valid), 64'd1);
  endtask

  task automatic insert(input logic [47:0] va, input logic [47:0] pa, input logic [1:0] sz,
                        input logic g, input logic w, input logic u, input logic unc);
    ins_pa = pa; ins_size = sz; ins_g = g; ins_w = w; ins_u = u; ins_unc = unc;
    issue(3'd1, va);
  endtask

  task automatic lookup(input logic [47:0] va, input logic t);
    touch = t; cpl = 2'd0; fsup = 0; wp = 0; acc_wr = 0; acc_sc = 0;
    issue(3'd0, va);
    touch = 0;
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid at reset", 64'(rsp_valid), 64'd0);
    chk("R1 ready", 64'(cmd_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 idle no rsp", 64'(rsp_valid), 64'd0);
    lookup(48'h1000, 0);
    chk("R1 empty miss", 64'(rsp_hit), 64'd0);

    // fill: idx0 4K, idx1 4K ro unc global, idx2 2M sup, idx3 1G ro sup global
    insert(48'h1000,     48'h555000,   2'd0, 0, 1, 1, 0);
    chk("R5 fill idx0", 64'({rsp_hit, rsp_idx}), 64'({1'b0, 2'd0}));
    insert(48'h2000,     48'h777000,   2'd0, 1, 0, 1, 1);
    chk("R5 fill idx1", 64'({rsp_hit, rsp_idx}), 64'({1'b0, 2'd1}));
    insert(48'h400000,   48'h12200000, 2'd1, 0, 1, 0, 0);
    chk("R5 fill idx2", 64'({rsp_hit, rsp_idx}), 64'({1'b0, 2'd2}));
    insert(48'h40000000, 48'h80000000, 2'd2, 1, 0, 0, 0);
    chk("R5 fill idx3", 64'({rsp_hit, rsp_idx}), 64'({1'b0, 2'd3}));

    for (int k = 0; k < NV; k++) begin
      cpl = VEC[k].cpl; fsup = VEC[k].fs; wp = VEC[k].wp;
      acc_wr = VEC[k].wr; acc_sc = VEC[k].sc; touch = 0;
      issue(3'd0, VEC[k].va);
      chk("R2 R3 hit", 64'(rsp_hit), 64'(VEC[k].hit));
      chk("R2 pa", 64'(rsp_pa), 64'(VEC[k].pa));
      chk("R10 fault", 64'(rsp_fault), 64'(VEC[k].flt));
      chk("R11 fault_write", 64'(rsp_fw), 64'(VEC[k].fw));
      chk("R12 uncache", 64'({rsp_unc, rsp_strict}), 64'({VEC[k].unc, VEC[k].unc}));
    end

    // R4 duplicate insert keeps existing
    insert(48'h1fff, 48'h999000, 2'd0, 1, 0, 0, 1);
    chk("R4 dup hit idx", 64'({rsp_hit, rsp_idx}), 64'({1'b1, 2'd0}));
    lookup(48'h1000, 0);
    chk("R4 dup pa kept", 64'(rsp_pa), 64'h555000);

    // R8 flush non-global
    issue(3'd3, 48'h0);
    lookup(48'h1000, 0);     chk("R8 ng idx0 gone", 64'(rsp_hit), 64'd0);
    lookup(48'h2000, 0);     chk("R8 g idx1 kept", 64'(rsp_hit), 64'd1);
    lookup(48'h400000, 0);   chk("R8 ng idx2 gone", 64'(rsp_hit), 64'd0);
    lookup(48'h40000000, 0); chk("R8 g idx3 kept", 64'(rsp_hit), 64'd1);

    // R9 demap
    issue(3'd4, 48'h2fff);
    chk("R9 demap hit", 64'(rsp_hit), 64'd1);
    lookup(48'h2000, 0);     chk("R9 demapped", 64'(rsp_hit), 64'd0);
    lookup(48'h40000000, 0); chk("R9 other kept", 64'(rsp_hit), 64'd1);
    issue(3'd4, 48'h5000);
    chk("R9 demap miss", 64'(rsp_hit), 64'd0);

    // R7 flush all
    issue(3'd2, 48'h0);
    lookup(48'h40000000, 0); chk("R7 all gone", 64'(rsp_hit), 64'd0);

    // R6 replacement
    insert(48'h10000, 48'h100000, 2'd0, 0, 1, 1, 0);
    insert(48'h20000, 48'h200000, 2'd0, 0, 1, 1, 0);
    insert(48'h30000, 48'h300000, 2'd0, 0, 1, 1, 0);
    insert(48'h40000, 48'h400000, 2'd0, 0, 1, 1, 0);
    chk("R5 refill idx3", 64'(rsp_idx), 64'd3);
    lookup(48'h10000, 1);
    insert(48'h50000, 48'h500000, 2'd0, 0, 1, 1, 0);
    chk("R6 evict oldest idx1", 64'({rsp_hit, rsp_idx}), 64'({1'b0, 2'd1}));
    lookup(48'h20000, 0); chk("R6 victim gone", 64'(rsp_hit), 64'd0);
    lookup(48'h10000, 0); chk("R6 touched kept", 64'(rsp_hit), 64'd1);
    lookup(48'h30000, 0);
    insert(48'h60000, 48'h600000, 2'd0, 0, 1, 1, 0);
    chk("R6 no-touch evicted idx2", 64'(rsp_idx), 64'd2);
    issue(3'd4, 48'h40000);
    insert(48'h70000, 48'h700000, 2'd0, 0, 1, 1, 0);
    chk("R5 free slot first idx3", 64'(rsp_idx), 64'd3);
    lookup(48'h70abc, 0);
    chk("R2 new entry pa", 64'(rsp_pa), 64'h700abc);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule